// File: doc/BRIEF.md
# Bank Device Select Unit

This block decides, once per control cycle, whether one device in a bank of identical devices takes part in that cycle. Two routes can select the device. The first is a pair of active-low hardware select lines: a shared line wired to every device, and a local line decoded per device. The second is a software route. Each device holds a select register with a disable flag and a target page code. When the flag is clear, the device also selects itself if the target code equals its own page address. The page address is the low nibble of a per-device configuration register.

The decision is captured when the active-low cycle enable falls, and it is held until the enable next falls. The core clock samples the enable and finds the falling edge, so a decision made at one edge can be seen after that clock edge. Writes to the select register and to the configuration register use a shared data bus. Each write strobe takes effect only in a cycle that selects the device. A write sent to every device over the shared line can therefore retarget the software route, or turn it off, across the whole bank at once. This removes the need for one select wire per device.

Top module: `bank_sel`

## Requirements
- R1: While reset is high, and after it, dev_sel is 0, sw_dis is 1, tgt_code is 0 and cfg_val is 0.
- R2: A cycle start (cyc_en_n seen low at a clock edge after being high at the previous edge) with gsel_n low sets dev_sel to 1 after that edge.
- R3: A cycle start with lsel_n low sets dev_sel to 1 after that edge.
- R4: A cycle start with both hardware lines high, sw_dis 0 and tgt_code equal to cfg_val[3:0] sets dev_sel to 1.
- R5: A cycle start with both hardware lines high and sw_dis 1 sets dev_sel to 0, even when tgt_code equals cfg_val[3:0].
- R6: A cycle start with both hardware lines high, sw_dis 0 and tgt_code not equal to cfg_val[3:0] sets dev_sel to 0.
- R7: dev_sel changes only at a cycle start. Changes on the select lines while the enable stays low or stays high have no effect.
- R8: dsr_we, sampled at a cycle start that selects the device, loads tgt_code from wr_data[3:0] and sw_dis from wr_data[8]. At any other edge the register holds.
- R9: cfg_we, sampled at a cycle start that selects the device, loads cfg_val from wr_data[7:0]. At any other edge it holds.
- R10: The decision at a cycle start uses the register values from before any write made at that same start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en_n | input | 1 | Active-low cycle enable; its falling edge starts a cycle |
| gsel_n | input | 1 | Shared active-low hardware select |
| lsel_n | input | 1 | Per-device active-low hardware select |
| cfg_we | input | 1 | Configuration register write strobe |
| dsr_we | input | 1 | Select register write strobe |
| wr_data | input | 16 | Write data for both registers |
| dev_sel | output | 1 | Latched select decision |
| sw_dis | output | 1 | Software select disable flag |
| tgt_code | output | 4 | Software target page code |
| cfg_val | output | 8 | Configuration register; low nibble is the page address |

## Verification
Every result appears one clock edge after the edge at which the falling enable is seen: the decision, the select register and the configuration register. The bench drives inputs on the falling clock edge, with the enable low. It reads all outputs on the next falling clock edge, so exactly one rising edge lies between stimulus and sample. To check R7, the bench raises the enable, moves the select lines, and lets a further rising edge pass. It then checks that nothing has changed before it starts the next cycle.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
    localparam int PAGE_W  = 4;
    localparam int CFG_W   = 8;
    localparam int DATA_W  = 16;
    localparam int DIS_POS = 8;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [CFG_W-1:0]  cfg_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  dis;
        page_t code;
    } dsr_t;

    localparam dsr_t DSR_RESET = '{dis: 1'b1, code: '0};

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HW   = 2'd1,
        SRC_SW   = 2'd2
    } sel_src_e;

    function automatic dsr_t dsr_from_bus(input data_t d);
        dsr_t r;
        r.dis  = d[DIS_POS];
        r.code = d[PAGE_W-1:0];
        return r;
    endfunction

    function automatic page_t page_of(input cfg_t c);
        return c[PAGE_W-1:0];
    endfunction
endpackage

// File: rtl/bank_sel_edge.sv
module bank_sel_edge (
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    output logic fall
);
    logic en_prev;

    always_ff @(posedge clk) begin
        if (rst) en_prev <= 1'b1;
        else     en_prev <= en_n;
    end

    assign fall = en_prev & ~en_n;
endmodule

// File: rtl/bank_sel_decide.sv
module bank_sel_decide
    import bank_sel_pkg::*;
(
    input  logic     gsel_n,
    input  logic     lsel_n,
    input  dsr_t     dsr,
    input  page_t    page,
    output logic     sel_now,
    output sel_src_e src
);
    logic [PAGE_W-1:0] bit_eq;
    logic hw_hit;
    logic sw_hit;

    for (genvar b = 0; b < PAGE_W; b++) begin : g_cmp
        assign bit_eq[b] = ~(dsr.code[b] ^ page[b]);
    end

    always_comb begin
        hw_hit  = ~gsel_n | ~lsel_n;
        sw_hit  = ~dsr.dis & (&bit_eq);
        sel_now = hw_hit | sw_hit;
        if (hw_hit)      src = SRC_HW;
        else if (sw_hit) src = SRC_SW;
        else             src = SRC_NONE;
    end
endmodule

// File: rtl/bank_sel_regs.sv
module bank_sel_regs
    import bank_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fall,
    input  logic  sel_now,
    input  logic  cfg_we,
    input  logic  dsr_we,
    input  data_t wr_data,
    output cfg_t  cfg_q,
    output dsr_t  dsr_q
);
    logic take;
    assign take = fall & sel_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            dsr_q <= DSR_RESET;
        end else if (take) begin
            if (cfg_we) cfg_q <= wr_data[CFG_W-1:0];
            if (dsr_we) dsr_q <= dsr_from_bus(wr_data);
        end
    end
endmodule

// File: rtl/bank_sel.sv
module bank_sel
    import bank_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en_n,
    input  logic              gsel_n,
    input  logic              lsel_n,
    input  logic              cfg_we,
    input  logic              dsr_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic              dev_sel,
    output logic              sw_dis,
    output logic [PAGE_W-1:0] tgt_code,
    output logic [CFG_W-1:0]  cfg_val
);
    logic     fall;
    logic     sel_now;
    sel_src_e src;
    cfg_t     cfg_q;
    dsr_t     dsr_q;
    logic     sel_q;

    bank_sel_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .en_n (cyc_en_n),
        .fall (fall)
    );

    bank_sel_decide u_dec (
        .gsel_n  (gsel_n),
        .lsel_n  (lsel_n),
        .dsr     (dsr_q),
        .page    (page_of(cfg_q)),
        .sel_now (sel_now),
        .src     (src)
    );

    bank_sel_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .sel_now (sel_now),
        .cfg_we  (cfg_we),
        .dsr_we  (dsr_we),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .dsr_q   (dsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)       sel_q <= 1'b0;
        else if (fall) sel_q <= (src != SRC_NONE);
    end

    assign dev_sel  = sel_q;
    assign sw_dis   = dsr_q.dis;
    assign tgt_code = dsr_q.code;
    assign cfg_val  = cfg_q;
endmodule

// File: rtl/bank_sel_chk.sv
module bank_sel_chk
    import bank_sel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cyc_en_n,
    input logic              gsel_n,
    input logic              lsel_n,
    input logic              dev_sel,
    input logic              sw_dis,
    input logic [PAGE_W-1:0] tgt_code,
    input logic [CFG_W-1:0]  cfg_val
);
    logic en_seen;
    logic start;

    always_ff @(posedge clk) begin
        if (rst) en_seen <= 1'b1;
        else     en_seen <= cyc_en_n;
    end
    assign start = en_seen & ~cyc_en_n;

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (!dev_sel && sw_dis && tgt_code == '0 && cfg_val == '0));

    // R2
    gsel_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !gsel_n) |=> dev_sel);

    // R3
    lsel_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !lsel_n) |=> dev_sel);

    // R5
    sw_off_chk: assert property (@(posedge clk) disable iff (rst)
        (start && gsel_n && lsel_n && sw_dis) |=> !dev_sel);

    // R7
    hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(dev_sel));

    // R8
    hold_dsr_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(tgt_code) && $stable(sw_dis)));

    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_val));
endmodule

bind bank_sel bank_sel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_en_n (cyc_en_n),
    .gsel_n   (gsel_n),
    .lsel_n   (lsel_n),
    .dev_sel  (dev_sel),
    .sw_dis   (sw_dis),
    .tgt_code (tgt_code),
    .cfg_val  (cfg_val)
);

// File: tb/tb_bank_sel.sv
module tb_bank_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_en_n = 1'b1;
    logic gsel_n = 1'b1;
    logic [NDEV-1:0] lsel_n = '1;
    logic cfg_we = 1'b0;
    logic dsr_we = 1'b0;
    logic [15:0] wr_data = '0;

    logic [NDEV-1:0] dev_sel;
    logic [NDEV-1:0] sw_dis;
    logic [3:0] tgt_code [NDEV];
    logic [7:0] cfg_val [NDEV];

    logic       dis_m  [NDEV];
    logic [3:0] code_m [NDEV];
    logic [7:0] cfg_m  [NDEV];
    logic       sel_m  [NDEV];

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        if (i == 0) begin : g_named
            bank_sel dut (
                .clk(clk), .rst(rst), .cyc_en_n(cyc_en_n), .gsel_n(gsel_n),
                .lsel_n(lsel_n[i]), .cfg_we(cfg_we), .dsr_we(dsr_we),
                .wr_data(wr_data), .dev_sel(dev_sel[i]), .sw_dis(sw_dis[i]),
                .tgt_code(tgt_code[i]), .cfg_val(cfg_val[i]));
        end else begin : g_other
            bank_sel u_dev (
                .clk(clk), .rst(rst), .cyc_en_n(cyc_en_n), .gsel_n(gsel_n),
                .lsel_n(lsel_n[i]), .cfg_we(cfg_we), .dsr_we(dsr_we),
                .wr_data(wr_data), .dev_sel(dev_sel[i]), .sw_dis(sw_dis[i]),
                .tgt_code(tgt_code[i]), .cfg_val(cfg_val[i]));
        end
    end

    task automatic check(input string req, input int dev, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s dev%0d %s actual=%0h expected=%0h", req, dev, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NDEV; i++) begin
            check(req, i, "dev_sel", int'(dev_sel[i]), int'(sel_m[i]));
            check(req, i, "sw_dis", int'(sw_dis[i]), int'(dis_m[i]));
            check(req, i, "tgt_code", int'(tgt_code[i]), int'(code_m[i]));
            check(req, i, "cfg_val", int'(cfg_val[i]), int'(cfg_m[i]));
        end
    endtask

    // Runs one control cycle; the model follows R2..R6, R8..R10.
    task automatic run_cycle(input string req, input logic g, input logic [NDEV-1:0] l,
                             input logic cw, input logic dw, input logic [15:0] d);
        @(negedge clk);
        gsel_n = g; lsel_n = l; cfg_we = cw; dsr_we = dw; wr_data = d;
        cyc_en_n = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            sel_m[i] = !g || !l[i] || (!dis_m[i] && code_m[i] == cfg_m[i][3:0]);
        end
        for (int i = 0; i < NDEV; i++) begin
            if (sel_m[i] && dw) begin dis_m[i] = d[8]; code_m[i] = d[3:0]; end
            if (sel_m[i] && cw) cfg_m[i] = d[7:0];
        end
        @(negedge clk);
        check_all(req);
        // R7: move lines and strobes with the enable held low, then high
        gsel_n = ~g; lsel_n = ~l; cfg_we = 1'b1; dsr_we = 1'b1; wr_data = ~d;
        @(negedge clk);
        check_all("R7");
        cyc_en_n = 1'b1;
        gsel_n = g; lsel_n = l;
        @(negedge clk);
        check_all("R7");
        gsel_n = 1'b1; lsel_n = '1; cfg_we = 1'b0; dsr_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NDEV; i++) begin
            dis_m[i] = 1'b1; code_m[i] = '0; cfg_m[i] = '0; sel_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R9 R3: give each device its own page through its local line
        for (int i = 0; i < NDEV; i++) begin
            logic [NDEV-1:0] l = '1;
            l[i] = 1'b0;
            run_cycle("R9", 1'b1, l, 1'b1, 1'b0, 16'h00A0 | 16'(3 + 2*i));
        end
        // R5: software path off after reset, no hardware select
        run_cycle("R5", 1'b1, '1, 1'b0, 1'b0, 16'h0);

        // R8 R4 R6 R5: broadcast every code with either disable value, then probe
        for (int dis = 0; dis < 2; dis++) begin
            for (int c = 0; c < 16; c++) begin
                run_cycle("R8", 1'b0, '1, 1'b0, 1'b1, 16'((dis << 8) | c));
                run_cycle(dis ? "R5" : "R4_R6", 1'b1, '1, 1'b0, 1'b0, 16'h0);
            end
        end

        // R2 R3: every hardware line pattern with the software path targeting device 1
        run_cycle("R8", 1'b0, '1, 1'b0, 1'b1, 16'h0005);
        for (int g = 0; g < 2; g++) begin
            for (int lm = 0; lm < (1 << NDEV); lm++) begin
                run_cycle(g ? "R3" : "R2", 1'(g), NDEV'(lm), 1'b0, 1'b0, 16'h0);
            end
        end

        // R10: a software-selected device rewrites its code in the same cycle
        run_cycle("R10", 1'b1, '1, 1'b0, 1'b1, 16'h0009);
        run_cycle("R10", 1'b1, '1, 1'b0, 1'b0, 16'h0);
        // R8: unselected devices ignore a write strobe
        run_cycle("R8", 1'b1, 4'b1101, 1'b1, 1'b1, 16'h0107);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule